// File: doc/BRIEF.md
# Non-Volatile Checkpoint Sequencing Controller

This controller sits beside a small processor whose architectural state is held in hybrid cells. Each cell has a volatile half and a non-volatile half. The controller watches a power-good level from a power monitor and filters it. When supply is lost, it stalls the core, requests the charge pump and waits for the pump to report ready. It then drives the cells' program/erase line to the positive high-voltage level for a programmed number of cycles. This copies every cell into its non-volatile half at once.

When supply returns and a valid checkpoint exists, the controller raises the cell enables for a single cycle so the volatile half settles to the stored value. It then releases the core. One cycle later it requests the pump again, and it erases all non-volatile halves in the background with the negative high-voltage level while the core runs.

If supply fails again before that erase completes, the erase is abandoned and no store is made. The next power-up then sees no valid checkpoint and issues a cold reset to the core instead of a restore. That cold path also finishes with a background erase, so every later store starts from erased cells.

Top module: `nvc_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released with power-good low, the core is stalled, `core_rst` is low, `cell_en` is low, `pe_mode` is 00 (idle) and `pump_req` is low.
- R2: In normal running, `cell_en` is low, `pe_mode` is 00, `pump_req` is low and `core_stall` is low.
- R3: Power-good is filtered over DEB_CYC consecutive samples. A low pulse shorter than DEB_CYC cycles during running has no effect on any output. A low level held for DEB_CYC cycles raises `core_stall` and `pump_req` DEB_CYC+1 cycles after the drop.
- R4: A store drives `pe_mode` to 01 (positive high voltage), with `cell_en` low and `core_stall` and `pump_req` high. It begins only after `pump_ready` is seen high. It lasts exactly `store_len` cycles, where a value of 0 counts as 1. After the store the controller idles with the core stalled and no pump request.
- R5: Once a store has begun, it always runs to its full length, even if power-good returns in the meantime. A restore follows it.
- R6: With a valid checkpoint, a filtered power return raises `cell_en` for exactly one cycle, DEB_CYC+1 cycles after the rise. During that cycle `pe_mode` is 00, the core is stalled and `core_rst` stays low.
- R7: The cycle after the restore (or the cold reset), `core_stall` is low and `pump_req` is still low. `pump_req` rises one cycle later.
- R8: A background erase drives `pe_mode` to 10 (negative high voltage), with `cell_en` low, `core_stall` low and `pump_req` high. It begins only after `pump_ready` is seen high and lasts exactly `erase_len` cycles, where 0 counts as 1. Normal running follows it.
- R9: A filtered power failure between release and the end of the erase drops `pump_req` and returns `pe_mode` to 00 with the core stalled. No store is made, and the next power-up gives a cold reset rather than a restore.
- R10: A power-up without a valid checkpoint (including the first one after `rst_n`) pulses `core_rst` for one cycle with the core stalled and never raises `cell_en`. A background erase follows it, as in R8.
- R11: `cell_en` and a non-idle `pe_mode` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Raw supply-good level from the power monitor |
| pump_ready | input | 1 | Charge pump has reached its level |
| store_len | input | LEN_W | Store step length in cycles (0 acts as 1) |
| erase_len | input | LEN_W | Erase step length in cycles (0 acts as 1) |
| cell_en | output | 1 | Cell enable lines, high only during restore |
| pe_mode | output | 2 | Program/erase drive: 00 idle, 01 positive, 10 negative |
| pump_req | output | 1 | Charge pump request |
| core_stall | output | 1 | Holds the core frozen |
| core_rst | output | 1 | One-cycle cold reset to the core |

## Verification
A supply drop or return reaches the outputs DEB_CYC+1 clock edges after it is driven: DEB_CYC samples in the filter, then one edge for the sequencer. The bench therefore samples the stall and enable outputs exactly one cycle before and at that edge. The release and the pump request follow the restore or cold-reset cycle by one and by two cycles. The bench samples those as single steps. The store and erase lengths depend on when the pump reports ready, so they are not checked at fixed edges. Instead, a monitor counts the cycles in which each high-voltage code is present, sampling on the falling edge, and the bench compares that count with the programmed length.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

  typedef enum logic [3:0] {
    ST_DOWN,
    ST_COLD,
    ST_RESTORE,
    ST_REL,
    ST_EPUMP,
    ST_ERASE,
    ST_RUN,
    ST_SPUMP,
    ST_STORE
  } nvc_state_e;

  localparam logic [1:0] PE_IDLE = 2'b00;
  localparam logic [1:0] PE_PROG = 2'b01;
  localparam logic [1:0] PE_WIPE = 2'b10;

endpackage

// File: rtl/nvc_pg_filter.sv
module nvc_pg_filter #(
  parameter int DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic [CW-1:0] cnt;
  logic          differs;
  logic          flip;

  assign differs = (raw != filt);
  assign flip    = differs && (cnt == CW'(DEB_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (flip) begin
      cnt  <= '0;
      filt <= raw;
    end else if (differs) begin
      cnt  <= cnt + 1'b1;
    end else begin
      cnt  <= '0;
    end
  end
endmodule

// File: rtl/nvc_step_timer.sv
module nvc_step_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] len,
  output logic         last
);
  logic [W-1:0] cnt;

  function automatic logic [W-1:0] final_index(input logic [W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  assign last = run && (cnt == final_index(len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run||last) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nvc_ctrl.sv
module nvc_ctrl
  import nvc_pkg::*;
#(
  parameter int DEB_CYC = 4,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             pump_ready,
  input  logic [LEN_W-1:0] store_len,
  input  logic [LEN_W-1:0] erase_len,
  output logic             cell_en,
  output logic [1:0]       pe_mode,
  output logic             pump_req,
  output logic             core_stall,
  output logic             core_rst
);
  nvc_state_e       state, state_nx;
  logic             pg_ok;
  logic             ckpt_valid;
  logic             step_run;
  logic             step_last;
  logic [LEN_W-1:0] step_len;

  // Named events for the checker
  logic ev_fail;
  logic ev_abort;
  logic ev_return;
  logic ev_store_done;
  logic in_bg;

  nvc_pg_filter #(.DEB_CYC(DEB_CYC)) u_filter (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (pwr_good),
    .filt (pg_ok)
  );

  assign step_run = (state == ST_STORE) || (state == ST_ERASE);
  assign step_len = (state == ST_STORE) ? store_len : erase_len;

  nvc_step_timer #(.W(LEN_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (step_run),
    .len  (step_len),
    .last (step_last)
  );

  assign in_bg         = (state == ST_REL) || (state == ST_EPUMP) || (state == ST_ERASE);
  assign ev_fail       = (state == ST_RUN) && !pg_ok;
  assign ev_abort      = in_bg && !pg_ok;
  assign ev_return     = (state == ST_DOWN) && pg_ok;
  assign ev_store_done = (state == ST_STORE) && step_last;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_DOWN:    if (pg_ok) state_nx = ckpt_valid ? ST_RESTORE : ST_COLD;
      ST_COLD:    state_nx = ST_REL;
      ST_RESTORE: state_nx = ST_REL;
      ST_REL:     state_nx = !pg_ok ? ST_DOWN : ST_EPUMP;
      ST_EPUMP: begin
        if (!pg_ok)          state_nx = ST_DOWN;
        else if (pump_ready) state_nx = ST_ERASE;
      end
      ST_ERASE: begin
        if (!pg_ok)          state_nx = ST_DOWN;
        else if (step_last)  state_nx = ST_RUN;
      end
      ST_RUN:     if (!pg_ok) state_nx = ST_SPUMP;
      ST_SPUMP:   if (pump_ready) state_nx = ST_STORE;
      ST_STORE:   if (step_last) state_nx = ST_DOWN;
      default:    state_nx = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_DOWN;
      ckpt_valid <= 1'b0;
    end else begin
      state <= state_nx;
      if (ev_store_done)  ckpt_valid <= 1'b1;
      else if (ev_return) ckpt_valid <= 1'b0;
    end
  end

  assign cell_en    = (state == ST_RESTORE);
  assign pe_mode    = (state == ST_STORE) ? PE_PROG :
                      (state == ST_ERASE) ? PE_WIPE : PE_IDLE;
  assign pump_req   = (state == ST_SPUMP) || (state == ST_STORE) ||
                      (state == ST_EPUMP) || (state == ST_ERASE);
  assign core_stall = (state == ST_DOWN) || (state == ST_COLD) || (state == ST_RESTORE) ||
                      (state == ST_SPUMP) || (state == ST_STORE);
  assign core_rst   = (state == ST_COLD);
endmodule

// File: rtl/nvc_ctrl_checker.sv
module nvc_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pump_ready,
  input logic       cell_en,
  input logic [1:0] pe_mode,
  input logic       pump_req,
  input logic       core_stall,
  input logic       core_rst,
  input logic       ev_fail,
  input logic       ev_abort
);
  a_r11_en_pe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en |-> (pe_mode == 2'b00));

  a_r4_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_mode == 2'b01) |-> (core_stall && pump_req && !cell_en));

  a_r4_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_req && core_stall && pe_mode == 2'b00 && !pump_ready) |=> (pe_mode == 2'b00));

  a_r5_store_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_mode == 2'b01) |=> ((pe_mode == 2'b01) || (core_stall && !pump_req)));

  a_r8_erase_background: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_mode == 2'b10) |-> (!core_stall && pump_req && !cell_en));

  a_r8_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_req && !core_stall && pe_mode == 2'b00 && !pump_ready) |=> (pe_mode == 2'b00));

  a_r6_single_restore: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en |=> !cell_en);

  a_r7_release_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en |=> (!core_stall && !pump_req));

  a_r10_cold_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (core_stall && !cell_en) ##1 (!core_rst && !core_stall));

  a_r3_fail_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> (core_stall && pump_req));

  a_r9_abort_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!pump_req && pe_mode == 2'b00 && core_stall));
endmodule

bind nvc_ctrl nvc_ctrl_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .pump_ready(pump_ready),
  .cell_en   (cell_en),
  .pe_mode   (pe_mode),
  .pump_req  (pump_req),
  .core_stall(core_stall),
  .core_rst  (core_rst),
  .ev_fail   (ev_fail),
  .ev_abort  (ev_abort)
);

// File: tb/tb_nvc_ctrl.sv
module tb_nvc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 4;
  localparam int LW  = 16;

  logic          clk = 1'b0;
  logic          rst_n, pwr_good, pump_ready;
  logic [LW-1:0] store_len, erase_len;
  logic          cell_en, pump_req, core_stall, core_rst;
  logic [1:0]    pe_mode;

  int n_chk = 0, n_bad = 0;
  int prog_cyc = 0, wipe_cyc = 0, en_cyc = 0, rst_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvc_ctrl #(.DEB_CYC(DEB), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pump_ready(pump_ready),
    .store_len(store_len), .erase_len(erase_len), .cell_en(cell_en),
    .pe_mode(pe_mode), .pump_req(pump_req), .core_stall(core_stall), .core_rst(core_rst)
  );

  // Cycle counters of each cell mode, sampled away from the active edge
  always @(negedge clk) begin
    if (pe_mode == 2'b01) prog_cyc++;
    if (pe_mode == 2'b10) wipe_cyc++;
    if (cell_en)          en_cyc++;
    if (core_rst)         rst_cyc++;
  end

  function automatic int eff_len(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int edge_delay();
    return DEB + 1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Waits until the block is in normal running: idle and unstalled for 3 samples
  task automatic wait_running(input string tag);
    int quiet = 0;
    for (int i = 0; i < 2000 && quiet < 3; i++) begin
      tick(1);
      if (!core_stall && !pump_req && !core_rst && !cell_en) quiet++;
      else quiet = 0;
    end
    chk({tag, " reached running"}, int'(quiet >= 3), 1);
  endtask

  task automatic wait_store_end(input string tag);
    bit seen = 0;
    for (int i = 0; i < 2000 && !(seen && !pump_req); i++) begin
      tick(1);
      if (pump_req) seen = 1;
    end
    chk({tag, " store ended"}, int'(!pump_req && core_stall), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int p0, w0, e0, r0, slen, elen, k;
    void'($urandom(32'd20150729));
    rst_n = 1'b0; pwr_good = 1'b0; pump_ready = 1'b0;
    store_len = 16'd12; erase_len = 16'd9;
    tick(3);
    chk("R1 stall in reset", core_stall, 1);
    chk("R1 pe idle in reset", pe_mode, 0);
    chk("R1 no pump in reset", pump_req, 0);
    chk("R1 no enable in reset", cell_en, 0);
    rst_n = 1'b1;
    tick(3);
    chk("R1 stall after reset", core_stall, 1);
    chk("R1 no core reset", core_rst, 0);

    // First power-up: cold path (R10)
    p0 = prog_cyc; w0 = wipe_cyc; e0 = en_cyc; r0 = rst_cyc;
    pwr_good = 1'b1;
    tick(edge_delay() - 1);
    chk("R10 no cold reset before filter", core_rst, 0);
    tick(1);
    chk("R10 cold reset pulse", core_rst, 1);
    chk("R10 stalled at cold reset", core_stall, 1);
    tick(1);
    chk("R7 released after cold", core_stall, 0);
    chk("R7 no pump on release", pump_req, 0);
    tick(1);
    chk("R7 pump one cycle later", pump_req, 1);
    tick(5);
    chk("R8 erase waits for ready", pe_mode, 0);
    pump_ready = 1'b1;
    wait_running("R8 cold");
    chk("R8 erase length", wipe_cyc - w0, eff_len(erase_len));
    chk("R10 no enable on cold", en_cyc - e0, 0);
    chk("R10 single core reset", rst_cyc - r0, 1);
    chk("R2 cell idle running", int'(cell_en || pe_mode != 0 || pump_req), 0);

    // Short power glitches are ignored (R3)
    for (int i = 0; i < 6; i++) begin
      k = 1 + int'($urandom % (DEB - 1));
      pwr_good = 1'b0;
      tick(k);
      pwr_good = 1'b1;
      tick(DEB + 3);
      chk("R3 glitch ignored stall", core_stall, 0);
      chk("R3 glitch ignored pump", pump_req, 0);
    end

    // Directed power failure and store (R3, R4)
    p0 = prog_cyc; e0 = en_cyc;
    pwr_good = 1'b0;
    tick(edge_delay() - 1);
    chk("R3 not yet stalled", core_stall, 0);
    tick(1);
    chk("R3 stalled at detect", core_stall, 1);
    chk("R4 pump requested", pump_req, 1);
    wait_store_end("R4");
    chk("R4 store length", prog_cyc - p0, eff_len(store_len));

    // Restore (R6, R7, R8)
    w0 = wipe_cyc; e0 = en_cyc; r0 = rst_cyc;
    pwr_good = 1'b1;
    tick(edge_delay() - 1);
    chk("R6 no enable before filter", cell_en, 0);
    tick(1);
    chk("R6 restore enable", cell_en, 1);
    chk("R6 stalled in restore", core_stall, 1);
    chk("R6 pe idle in restore", pe_mode, 0);
    tick(1);
    chk("R7 released after restore", core_stall, 0);
    chk("R6 enable one cycle", cell_en, 0);
    chk("R7 no pump on release", pump_req, 0);
    tick(1);
    chk("R7 pump follows release", pump_req, 1);
    wait_running("R8 restore");
    chk("R6 single enable", en_cyc - e0, 1);
    chk("R6 no core reset", rst_cyc - r0, 0);
    chk("R8 erase length", wipe_cyc - w0, eff_len(erase_len));

    // Random store/erase lengths, with pump delay and power return mid-store (R4, R5, R8)
    for (int i = 0; i < 5; i++) begin
      slen = (i == 0) ? 0 : 20 + int'($urandom % 30);
      elen = (i == 1) ? 0 : int'($urandom % 40);
      store_len = LW'(slen); erase_len = LW'(elen);
      p0 = prog_cyc; w0 = wipe_cyc; e0 = en_cyc;
      pump_ready = 1'b0;
      pwr_good = 1'b0;
      tick(edge_delay() + 3);
      chk("R4 store waits for ready", pe_mode, 0);
      pump_ready = 1'b1;
      if (i != 0) begin
        tick(3);
        pwr_good = 1'b1;
        wait_store_end("R5");
        chk("R5 full store despite return", prog_cyc - p0, eff_len(slen));
      end else begin
        wait_store_end("R4");
        chk("R4 zero length store", prog_cyc - p0, 1);
        pwr_good = 1'b1;
      end
      wait_running("R8 random");
      chk("R5 restore follows", en_cyc - e0, 1);
      chk("R8 random erase length", wipe_cyc - w0, eff_len(elen));
    end

    // Glitch exactly DEB long is a failure (R3 boundary)
    store_len = 16'd8; erase_len = 16'd40;
    pwr_good = 1'b0;
    tick(DEB);
    pwr_good = 1'b1;
    tick(1);
    chk("R3 boundary glitch detected", core_stall, 1);
    wait_store_end("R3 boundary");

    // Abort during background erase (R9), then cold power-up (R10)
    for (int i = 0; i < 2000 && pe_mode != 2'b10; i++) tick(1);
    chk("R9 erase reached", pe_mode, 2);
    tick(3);
    p0 = prog_cyc; e0 = en_cyc; r0 = rst_cyc;
    pwr_good = 1'b0;
    tick(edge_delay());
    chk("R9 erase aborted pe", pe_mode, 0);
    chk("R9 pump dropped", pump_req, 0);
    chk("R9 core stalled", core_stall, 1);
    tick(20);
    chk("R9 no store made", prog_cyc - p0, 0);
    pwr_good = 1'b1;
    tick(edge_delay());
    chk("R9 cold reset instead of restore", core_rst, 1);
    wait_running("R10 after abort");
    chk("R10 no enable after abort", en_cyc - e0, 0);
    chk("R2 running idle", int'(core_stall || pump_req || cell_en), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule